// File: doc/BRIEF.md
# Cache Slice Activation Register Block

This block is the software-visible control face of a partitioned last-level cache. Each cache slice has its own command register and status register, plus two attribute registers. The attribute registers carry the way masks, the priority, the capacity and the mode bits that the cache datapath reads directly from this block's outputs. A read-only common word reports how many banks the cache has.

Software brings a slice up or down with two writes. The first writes an opcode with the trigger bit set, and the second writes the same opcode with the trigger bit cleared. The block acts only on the rising edge of the stored trigger bit. A small per-slice sequencer then holds the slice in a transitional status for a fixed number of cycles before it settles. Software polls the status register until the bit it waits on has cleared. After an activate it waits for the deactivated bit to clear, and after a deactivate it waits for the active bit to clear.

The bus is a plain 32-bit strobe interface. Read data is registered and appears the cycle after the read strobe.

Top module: `slice_ctl_regs`

## Requirements
- R1: Registers are 32 bits wide and word aligned. The command register of slice s is at s×0x1000 and its status register is at s×0x1000+4. The attribute registers A and B of slice s are at 0x21000+8×s and 0x21000+8×s+4. The common word is at 0x3000C. A read strobe sampled on a clock edge places that register's value on bus_rdata after that same edge.
- R2: In the command register, bit 0 is the trigger and bits [2:1] are the opcode. Bits [2:0] read back as last written and all other bits read as zero. A command starts only when a write sets the trigger while the stored trigger is 0. A repeated write with the trigger still set starts nothing.
- R3: Opcode 1 (activate) sets the status to 2'b11 from the write edge for ACT_LATENCY cycles, then to 2'b01 (bit 0 active, bit 1 deactivated). slice_on is high exactly when the status is 2'b01.
- R4: Opcode 2 (deactivate) sets the status to 2'b11 for ACT_LATENCY cycles, then to 2'b10.
- R5: After reset, every status is 2'b10, every command register reads 0, every attribute register reads 0 and slice_on is all zero.
- R6: A trigger that carries opcode 0 or opcode 3 leaves the status unchanged.
- R7: A trigger that arrives while the slice's command is in flight is ignored. This includes a trigger on the edge where the command completes. The first command finishes on its own schedule.
- R8: Writes to a status register have no effect.
- R9: Attribute register B holds the cache mode in bits [1:0], the probe-target flag in bit 2, the fixed-size flag in bit 3, the priority in bits [4+PRIO_W-1:4] and the capacity in 64-byte lines per bank in bits [31:16]. Other bits read as 0. Each field drives the matching per-slice output.
- R10: Attribute register A holds the reserved-way mask in bits [WAYS-1:0] and the bonus-way mask in bits [16+WAYS-1:16]. Other bits read as 0. Both masks drive per-slice outputs.
- R11: The common word reads BANK_COUNT in bits [31:28] and zero elsewhere. Writes to it have no effect.
- R12: Reads from unmapped or misaligned addresses return 0, and writes to them change no register. This includes slice numbers at or above NUM_SLICES.
- R13: Commands to different slices run independently and may overlap in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| slice_on | output | NUM_SLICES | Slice has settled in the active state |
| slice_mode | output | 2×NUM_SLICES | Cache mode per slice |
| slice_probe | output | NUM_SLICES | Probe-target-ways flag per slice |
| slice_fixed | output | NUM_SLICES | Fixed-size flag per slice |
| slice_prio | output | PRIO_W×NUM_SLICES | Priority per slice |
| slice_cap | output | 16×NUM_SLICES | Capacity limit in lines per bank |
| slice_resv | output | WAYS×NUM_SLICES | Reserved-way mask per slice |
| slice_bonus | output | WAYS×NUM_SLICES | Bonus-way mask per slice |

## Verification
Two events can land on the same edge: a slice's command completing, and a bus access to that same slice. A status read sampled on the completion edge must still return 2'b11, and the read one cycle later returns the settled value. The bench issues back-to-back status reads straight after a command and expects the exact cycle of the change. A second case writes a fresh trigger on exactly the completion edge. That trigger must be dropped, which the bench confirms by reading the status well after the point where the dropped command would have settled.

// File: rtl/slc_pkg.sv
// Shared constants and types for the cache slice activation register block.
// Assumes byte addressing and 32-bit word registers.
package slc_pkg;

    localparam logic [31:0] CTRL_STRIDE = 32'h0000_1000;
    localparam logic [31:0] ATTR_BASE   = 32'h0002_1000;
    localparam logic [31:0] COMMON_ADDR = 32'h0003_000C;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_UP    = 2'd1,
        OP_DOWN  = 2'd2,
        OP_RSVD  = 2'd3
    } slc_op_e;

    // status encoding: bit0 = active, bit1 = deactivated
    localparam logic [1:0] ST_OFF  = 2'b10;
    localparam logic [1:0] ST_ON   = 2'b01;
    localparam logic [1:0] ST_MOVE = 2'b11;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_STAT,
        RG_ATTR_A,
        RG_ATTR_B,
        RG_COMMON
    } slc_region_e;

endpackage

// File: rtl/slc_addr_dec.sv
// Address decoder: maps a byte address to a register region and slice index.
// Assumes ADDR_W >= 18 so the common word is reachable; anything that is not
// an exact, aligned hit on a mapped register decodes as RG_NONE.
module slc_addr_dec
    import slc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int NS     = 4,
    parameter int SID_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output slc_region_e       region,
    output logic [SID_W-1:0]  sid
);

    logic [31:0] a32;
    logic [31:0] attr_off;
    logic [31:0] ctrl_idx;

    assign a32      = 32'(addr);
    assign attr_off = a32 - ATTR_BASE;
    assign ctrl_idx = a32 >> 12;

    // Region and index selection
    always_comb begin
        region = RG_NONE;
        sid    = '0;
        if (a32 == COMMON_ADDR) begin
            region = RG_COMMON;
        end else if (ctrl_idx < 32'(NS) && a32[11:3] == 9'd0 && a32[1:0] == 2'b00) begin
            region = a32[2] ? RG_STAT : RG_CTRL;
            sid    = a32[12 +: SID_W];
        end else if (a32 >= ATTR_BASE && attr_off < 32'(8 * NS) && attr_off[1:0] == 2'b00) begin
            region = attr_off[2] ? RG_ATTR_B : RG_ATTR_A;
            sid    = attr_off[3 +: SID_W];
        end
    end

endmodule

// File: rtl/slc_slice_ctl.sv
// Per-slice command register and activation sequencer.
// Starts a command on a rising edge of the stored trigger bit when the opcode
// is activate or deactivate and no command is in flight; the status shows
// 2'b11 for LAT cycles, then settles. Assumes LAT >= 1.
module slc_slice_ctl
    import slc_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [2:0] cmd_wdata,
    output logic [2:0] cmd_q,
    output logic [1:0] status,
    output logic       busy
);

    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

    logic [CNT_W-1:0] cnt;
    logic             going_up;
    slc_op_e          op;
    logic             start;

    assign op    = slc_op_e'(cmd_wdata[2:1]);
    assign start = cmd_we && cmd_wdata[0] && !cmd_q[0] && (op == OP_UP || op == OP_DOWN);

    // Command register storage and sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= 3'd0;
            status   <= ST_OFF;
            busy     <= 1'b0;
            cnt      <= '0;
            going_up <= 1'b0;
        end else begin
            if (cmd_we) cmd_q <= cmd_wdata;
            if (busy) begin
                if (cnt == '0) begin
                    busy   <= 1'b0;
                    status <= going_up ? ST_ON : ST_OFF;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (start) begin
                busy     <= 1'b1;
                cnt      <= CNT_W'(LAT - 1);
                status   <= ST_MOVE;
                going_up <= (op == OP_UP);
            end
        end
    end

endmodule

// File: rtl/slc_slice_attr.sv
// Per-slice attribute storage: register A (way masks) and register B
// (mode, flags, priority, capacity). Unimplemented bits are dropped on write,
// so they read as zero. Assumes WAYS <= 12 and PRIO_W <= 12.
module slc_slice_attr #(
    parameter int PRIO_W = 4,
    parameter int WAYS   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_a,
    input  logic              we_b,
    input  logic [31:0]       wdata,
    output logic [31:0]       reg_a,
    output logic [31:0]       reg_b,
    output logic [1:0]        mode,
    output logic              probe,
    output logic              fixed,
    output logic [PRIO_W-1:0] prio,
    output logic [15:0]       cap,
    output logic [WAYS-1:0]   resv,
    output logic [WAYS-1:0]   bonus
);

    localparam logic [31:0] WAY_M  = (32'd1 << WAYS) - 32'd1;
    localparam logic [31:0] MASK_A = WAY_M | (WAY_M << 16);
    localparam logic [31:0] MASK_B = 32'hFFFF_000F | (((32'd1 << PRIO_W) - 32'd1) << 4);

    // Masked attribute register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a <= '0;
            reg_b <= '0;
        end else begin
            if (we_a) reg_a <= wdata & MASK_A;
            if (we_b) reg_b <= wdata & MASK_B;
        end
    end

    assign resv  = reg_a[WAYS-1:0];
    assign bonus = reg_a[16 +: WAYS];
    assign mode  = reg_b[1:0];
    assign probe = reg_b[2];
    assign fixed = reg_b[3];
    assign prio  = reg_b[4 +: PRIO_W];
    assign cap   = reg_b[31:16];

endmodule

// File: rtl/slice_ctl_regs.sv
// Top of the cache slice activation register block. Decodes the bus, owns
// one command sequencer and one attribute pair per slice, and registers the
// read data. Assumes single-cycle write and read strobes, never both at once.
module slice_ctl_regs
    import slc_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int NUM_SLICES  = 4,
    parameter int ACT_LATENCY = 4,
    parameter int BANK_COUNT  = 2,
    parameter int PRIO_W      = 4,
    parameter int WAYS        = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic [NUM_SLICES-1:0]        slice_on,
    output logic [2*NUM_SLICES-1:0]      slice_mode,
    output logic [NUM_SLICES-1:0]        slice_probe,
    output logic [NUM_SLICES-1:0]        slice_fixed,
    output logic [PRIO_W*NUM_SLICES-1:0] slice_prio,
    output logic [16*NUM_SLICES-1:0]     slice_cap,
    output logic [WAYS*NUM_SLICES-1:0]   slice_resv,
    output logic [WAYS*NUM_SLICES-1:0]   slice_bonus
);

    localparam int SID_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
    localparam logic [31:0] COMMON_VAL = 32'(BANK_COUNT) << 28;

    slc_region_e           rg;
    logic [SID_W-1:0]      sid;
    logic [2:0]            cmd_q   [NUM_SLICES];
    logic [31:0]           attr_a  [NUM_SLICES];
    logic [31:0]           attr_b  [NUM_SLICES];
    logic [2*NUM_SLICES-1:0] st_flat;
    logic [NUM_SLICES-1:0] busy_vec;
    logic [31:0]           rd_mux;

    slc_addr_dec #(.ADDR_W(ADDR_W), .NS(NUM_SLICES), .SID_W(SID_W)) u_dec (
        .addr   (bus_addr),
        .region (rg),
        .sid    (sid)
    );

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        logic hit;
        assign hit = bus_wr && (sid == SID_W'(i));

        slc_slice_ctl #(.LAT(ACT_LATENCY)) u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_we    (hit && rg == RG_CTRL),
            .cmd_wdata (bus_wdata[2:0]),
            .cmd_q     (cmd_q[i]),
            .status    (st_flat[2*i +: 2]),
            .busy      (busy_vec[i])
        );

        slc_slice_attr #(.PRIO_W(PRIO_W), .WAYS(WAYS)) u_attr (
            .clk   (clk),
            .rst_n (rst_n),
            .we_a  (hit && rg == RG_ATTR_A),
            .we_b  (hit && rg == RG_ATTR_B),
            .wdata (bus_wdata),
            .reg_a (attr_a[i]),
            .reg_b (attr_b[i]),
            .mode  (slice_mode[2*i +: 2]),
            .probe (slice_probe[i]),
            .fixed (slice_fixed[i]),
            .prio  (slice_prio[PRIO_W*i +: PRIO_W]),
            .cap   (slice_cap[16*i +: 16]),
            .resv  (slice_resv[WAYS*i +: WAYS]),
            .bonus (slice_bonus[WAYS*i +: WAYS])
        );

        assign slice_on[i] = (st_flat[2*i +: 2] == ST_ON);
    end

    // Read data selection by region and slice
    always_comb begin
        rd_mux = '0;
        if (32'(sid) < 32'(NUM_SLICES)) begin
            case (rg)
                RG_CTRL:   rd_mux = {29'd0, cmd_q[sid]};
                RG_STAT:   rd_mux = {30'd0, st_flat[2*sid +: 2]};
                RG_ATTR_A: rd_mux = attr_a[sid];
                RG_ATTR_B: rd_mux = attr_b[sid];
                RG_COMMON: rd_mux = COMMON_VAL;
                default:   rd_mux = '0;
            endcase
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/slc_regs_chk.sv
// Assertion checker for slice_ctl_regs, attached by bind below. Observes the
// decoded region, the per-slice status and sequencer busy flags, and the bus.
module slc_regs_chk
    import slc_pkg::*;
#(
    parameter int NS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input slc_region_e   region,
    input logic [31:0]   bus_rdata,
    input logic [2*NS-1:0] status_flat,
    input logic [NS-1:0] busy
);

    for (genvar i = 0; i < NS; i++) begin : g_chk
        // R3
        status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status_flat[2*i +: 2] != 2'b00);
        // R3
        up_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status_flat[2*i+1]) |-> status_flat[2*i]);
        // R4
        down_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status_flat[2*i]) |-> status_flat[2*i+1]);
        // R7
        busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
            busy[i] |-> status_flat[2*i +: 2] == 2'b11);
    end

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && region == RG_NONE) |=> bus_rdata == 32'd0);
    // R11
    common_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && region == RG_COMMON) |=> bus_rdata[27:0] == 28'd0);

endmodule

bind slice_ctl_regs slc_regs_chk #(.NS(NUM_SLICES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .region      (rg),
    .bus_rdata   (bus_rdata),
    .status_flat (st_flat),
    .busy        (busy_vec)
);

// File: tb/sim_slice_ctl_regs.sv
// Scoreboard bench: bus tasks push expected read data, a monitor pops and
// compares it on the falling edge after the read is sampled.
module sim_slice_ctl_regs;

    localparam int ADDR_W = 20;
    localparam int NS     = 4;
    localparam int LAT    = 4;
    localparam int BANKS  = 2;
    localparam int PRIO_W = 4;
    localparam int WAYS   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS-1:0] slice_on, slice_probe, slice_fixed;
    logic [2*NS-1:0] slice_mode;
    logic [PRIO_W*NS-1:0] slice_prio;
    logic [16*NS-1:0] slice_cap;
    logic [WAYS*NS-1:0] slice_resv, slice_bonus;

    int checks = 0;
    int failures = 0;
    logic rd_q = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    slice_ctl_regs #(.ADDR_W(ADDR_W), .NUM_SLICES(NS), .ACT_LATENCY(LAT),
                     .BANK_COUNT(BANKS), .PRIO_W(PRIO_W), .WAYS(WAYS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slice_on(slice_on), .slice_mode(slice_mode), .slice_probe(slice_probe),
        .slice_fixed(slice_fixed), .slice_prio(slice_prio), .slice_cap(slice_cap),
        .slice_resv(slice_resv), .slice_bonus(slice_bonus)
    );

    function automatic logic [31:0] a_cmd(int s);  return 32'(s) * 32'h1000; endfunction
    function automatic logic [31:0] a_st(int s);   return 32'(s) * 32'h1000 + 32'd4; endfunction
    function automatic logic [31:0] a_atA(int s);  return 32'h21000 + 32'(8 * s); endfunction
    function automatic logic [31:0] a_atB(int s);  return 32'h21004 + 32'(8 * s); endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a[ADDR_W-1:0];
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
        end
    endtask

    // Monitor: note which edges sampled a read
    always @(posedge clk) rd_q <= bus_rd;

    // Monitor: compare registered read data against the scoreboard
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R1 unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R5 reset state
        rd(a_cmd(0), 32'd0, "R5 cmd reset");
        rd(a_st(0), 32'd2, "R5 status reset");
        rd(a_atB(1), 32'd0, "R5 attr reset");
        idle(1);
        check(32'(slice_on), 32'd0, "R5 slice_on reset");

        // R3 activate: status 11 through the completion edge, then 01
        wr(a_cmd(0), 32'h3);
        wr(a_cmd(0), 32'h2);
        for (int k = 2; k <= LAT + 1; k++)
            rd(a_st(0), (k <= LAT) ? 32'd3 : 32'd1, "R3 activate status timing");
        idle(1);
        check(32'(slice_on[0]), 32'd1, "R3 slice_on after activate");

        // R4 deactivate: status 11 then 10
        wr(a_cmd(0), 32'h5);
        wr(a_cmd(0), 32'h4);
        for (int k = 2; k <= LAT + 1; k++)
            rd(a_st(0), (k <= LAT) ? 32'd3 : 32'd2, "R4 deactivate status timing");
        idle(1);
        check(32'(slice_on[0]), 32'd0, "R4 slice_on after deactivate");

        // R2 trigger held high: second command is not an edge
        wr(a_cmd(1), 32'h3);
        idle(LAT + 1);
        rd(a_st(1), 32'd1, "R2 first trigger activates");
        wr(a_cmd(1), 32'h5);
        idle(LAT + 1);
        rd(a_st(1), 32'd1, "R2 held trigger ignored");
        rd(a_cmd(1), 32'd5, "R2 command readback");
        wr(a_cmd(1), 32'hFFFF_FFF8);
        rd(a_cmd(1), 32'd0, "R2 upper bits read zero");

        // R7 trigger during an in-flight command
        wr(a_cmd(2), 32'h3);
        wr(a_cmd(2), 32'h2);
        wr(a_cmd(2), 32'h5);
        wr(a_cmd(2), 32'h4);
        idle(LAT);
        rd(a_st(2), 32'd1, "R7 mid-flight trigger ignored");

        // R7 trigger on the completion edge
        wr(a_cmd(3), 32'h3);
        wr(a_cmd(3), 32'h2);
        idle(LAT - 2);
        wr(a_cmd(3), 32'h5);
        wr(a_cmd(3), 32'h4);
        idle(LAT + 1);
        rd(a_st(3), 32'd1, "R7 completion-edge trigger ignored");

        // R6 reserved and null opcodes
        wr(a_cmd(2), 32'h7);
        idle(LAT + 1);
        rd(a_st(2), 32'd1, "R6 opcode 3 ignored");
        wr(a_cmd(2), 32'h6);
        wr(a_cmd(2), 32'h1);
        idle(LAT + 1);
        rd(a_st(2), 32'd1, "R6 opcode 0 ignored");

        // R13 overlapping commands on two slices
        wr(a_cmd(1), 32'h4);
        wr(a_cmd(0), 32'h3);
        wr(a_cmd(1), 32'h5);
        rd(a_st(0), 32'd3, "R13 slice0 in flight");
        rd(a_st(1), 32'd3, "R13 slice1 in flight");
        idle(LAT);
        rd(a_st(0), 32'd1, "R13 slice0 settled on");
        rd(a_st(1), 32'd2, "R13 slice1 settled off");

        // R8 status is read-only
        wr(a_st(0), 32'h0);
        rd(a_st(0), 32'd1, "R8 status write ignored");

        // R9 attribute register B
        wr(a_atB(3), 32'hFFFF_FFFF);
        rd(a_atB(3), 32'hFFFF_0000 | ((32'd1 << (4 + PRIO_W)) - 32'd1), "R9 B mask");
        wr(a_atB(3), 32'h00AB_0036);
        idle(1);
        check(32'(slice_mode[6 +: 2]), 32'd2, "R9 mode field");
        check(32'(slice_probe[3]), 32'd1, "R9 probe field");
        check(32'(slice_fixed[3]), 32'd0, "R9 fixed field");
        check(32'(slice_prio[PRIO_W*3 +: PRIO_W]), 32'd3, "R9 priority field");
        check(32'(slice_cap[48 +: 16]), 32'h00AB, "R9 capacity field");

        // R10 attribute register A
        wr(a_atA(2), 32'hFFFF_FFFF);
        rd(a_atA(2), 32'h0FFF_0FFF, "R10 A mask");
        wr(a_atA(2), 32'h0123_0456);
        idle(1);
        check(32'(slice_resv[WAYS*2 +: WAYS]), 32'h456, "R10 reserved ways");
        check(32'(slice_bonus[WAYS*2 +: WAYS]), 32'h123, "R10 bonus ways");
        rd(a_atB(3), 32'h00AB_0036, "R10 neighbour untouched");

        // R11 common word
        rd(32'h3000C, 32'(BANKS) << 28, "R11 bank count");
        wr(32'h3000C, 32'h0);
        rd(32'h3000C, 32'(BANKS) << 28, "R11 write ignored");

        // R12 unmapped and misaligned
        wr(a_cmd(NS), 32'h5);
        rd(a_cmd(0), 32'd3, "R12 no alias onto slice0");
        rd(a_cmd(NS), 32'd0, "R12 slice beyond range");
        wr(a_atA(NS), 32'hFFFF_FFFF);
        rd(a_atA(NS), 32'd0, "R12 attr beyond range");
        rd(a_atA(0), 32'd0, "R12 attr slice0 untouched");
        rd(32'h2, 32'd0, "R12 misaligned");
        rd(32'h21002, 32'd0, "R12 misaligned attr");
        idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule